// File: doc/BRIEF.md
# Decode-Stage Hazard Checker for Mixed-Latency Execution Units

This block is the stall generator in the decode stage of an in-order, single-issue pipeline. The pipeline sends work to four execution resources: an integer unit, a pipelined floating-point adder, a pipelined multiplier, and a divider that is not pipelined. Each cycle the checker sees one decoded instruction: which unit it targets, two source registers and one destination register, plus a valid strobe. It raises `stall` when that instruction must wait. When `stall` is low and the strobe is high, the instruction leaves decode in that cycle and the checker records it.

In-flight results are held in one shift register indexed by the number of cycles left until write-back. Each occupied position stores the destination and whether the result comes from one of the long units. The same structure reserves the single register-file write port and answers the read-after-write and write-after-write questions. A small countdown tracks how long the divider stays occupied. Because operands are read in program order in decode, write-after-read needs no logic. Write-after-write is always resolved by stalling the younger instruction.

The cycle model works as follows. An instruction that issues at cycle t with execute latency L claims the write port at cycle t+L+3. A dependent instruction can issue at cycle t+L+1 at the earliest. The execute latencies are: integer 0, adder 3, multiplier 6, divider 24. The divider accepts a new operation at most once every 25 cycles.

Top module: `hazard_gate`

## Requirements
- R1: A synchronous active-high `rst` empties all in-flight records and frees the divider, so the first valid instruction after reset does not stall, whatever it is.
- R2: The unit code is 0 integer, 1 adder, 2 multiplier, 3 divider. An integer result is usable at once: a dependent instruction right after an integer producer does not stall.
- R3: A source that matches the destination of an in-flight adder result stalls decode for exactly 3 cycles after the producer issues. The source is a register number plus a space flag, where 1 is floating point and 0 is integer.
- R4: A source that matches an in-flight multiplier result stalls decode for exactly 6 cycles.
- R5: A divide stalls while an earlier divide issued fewer than 25 cycles ago. For back-to-back attempts this gives 24 stall cycles.
- R6: An instruction with a live destination stalls if its write-back cycle (issue cycle + latency + 3) is already claimed by an in-flight result.
- R7: An instruction whose destination equals that of an in-flight adder, multiplier or divider result stalls up to and including that result's write-back cycle. A matching destination of an in-flight integer result does not stall.
- R8: Integer register 0 is never a hazard. As a source it never stalls. As a destination it is not recorded and claims no write-back slot.
- R9: The integer and floating-point register spaces are separate: the same number in the other space never matches.
- R10: `stall` is low whenever `dec_valid` is low. An instruction that stalls leaves no record behind.
- R11: Writing a register that an already-issued instruction reads never stalls (no write-after-read check).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A decoded instruction is present |
| dec_unit | input | 2 | Target unit: 0 int, 1 add, 2 mul, 3 div |
| src_a_fp | input | 1 | Space of source A (1 = floating point) |
| src_a_idx | input | 5 | Register number of source A |
| src_b_fp | input | 1 | Space of source B |
| src_b_idx | input | 5 | Register number of source B |
| dst_fp | input | 1 | Space of the destination |
| dst_idx | input | 5 | Register number of the destination (integer 0 = none) |
| stall | output | 1 | Hold the instruction in decode this cycle |

## Verification
The bench measures exact stall lengths behind adder, multiplier and divider producers. A design off by one in its record positions would stall one cycle too few and hand over stale data, or one cycle too many and lose throughput. It sets up write-port collisions between a long-latency producer and a later short one. A design that skips the reservation would let two results reach the single write port in the same cycle. It also issues a same-destination write behind a multiply and expects a wait through the multiply's write-back; an unguarded design would let the younger value be overwritten. Further cases cover register-space aliasing, integer register 0, write-after-read and stalled instructions that must leave no trace. Random traffic with a narrow register range then compares every cycle against an absolute-time model in the bench.

// File: rtl/hc_pkg.sv
package hc_pkg;
    localparam int REG_W = 5;

    typedef enum logic [1:0] {
        UNIT_INT = 2'd0,
        UNIT_ADD = 2'd1,
        UNIT_MUL = 2'd2,
        UNIT_DIV = 2'd3
    } hc_unit_e;

    typedef struct packed {
        logic             fp;
        logic [REG_W-1:0] idx;
    } reg_t;

    typedef struct packed {
        logic busy;
        logic long_unit;
        reg_t dst;
    } slot_t;

    // Integer register 0 is hardwired and never tracked.
    function automatic logic is_live(reg_t r);
        return r.fp || (r.idx != '0);
    endfunction

    function automatic logic same_reg(reg_t a, reg_t b);
        return is_live(a) && (a == b);
    endfunction
endpackage

// File: rtl/hc_wb_track.sv
module hc_wb_track
    import hc_pkg::*;
#(
    parameter int DEPTH = 28,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ins_en,
    input  logic [PW-1:0]       ins_pos,
    input  slot_t               ins_slot,
    output slot_t [DEPTH-1:0]   slots_o
);
    typedef struct packed {
        slot_t [DEPTH-1:0] slots;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            st_d.slots[i] = (i == DEPTH - 1) ? '0 : st_q.slots[i+1];
        end
        if (ins_en) begin
            st_d.slots[ins_pos] = ins_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign slots_o = st_q.slots;

    AST_WB_SLOT_FREE: assert property (@(posedge clk) disable iff (rst)
        ins_en |-> !st_q.slots[ins_pos + PW'(1)].busy); // R6
    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (st_q == '0)); // R1
endmodule

// File: rtl/hc_div_gate.sv
module hc_div_gate #(
    parameter int DIV_II = 25,
    localparam int CW    = $clog2(DIV_II + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start)                st_d.cnt = CW'(DIV_II - 1);
        else if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);

    AST_DIV_NOT_BUSY_AT_START: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R5
endmodule

// File: rtl/hc_scan.sv
module hc_scan
    import hc_pkg::*;
#(
    parameter int DEPTH = 28,
    parameter int POST  = 2,
    localparam int PW   = $clog2(DEPTH)
) (
    input  slot_t [DEPTH-1:0] slots,
    input  reg_t              src_a,
    input  reg_t              src_b,
    input  reg_t              dst,
    input  logic [PW-1:0]     chk_pos,
    output logic              raw_hz,
    output logic              waw_hz,
    output logic              port_taken
);
    always_comb begin
        raw_hz     = 1'b0;
        waw_hz     = 1'b0;
        port_taken = slots[chk_pos].busy;
        for (int i = 0; i < DEPTH; i++) begin
            if (slots[i].busy) begin
                // Result not yet forwardable while more than POST cycles remain.
                if ((i > POST) &&
                    (same_reg(src_a, slots[i].dst) || same_reg(src_b, slots[i].dst))) begin
                    raw_hz = 1'b1;
                end
                if (slots[i].long_unit && same_reg(dst, slots[i].dst)) begin
                    waw_hz = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hazard_gate.sv
module hazard_gate
    import hc_pkg::*;
#(
    parameter int ADD_LAT = 3,
    parameter int MUL_LAT = 6,
    parameter int DIV_LAT = 24,
    parameter int DIV_II  = 25,
    parameter int POST    = 2,
    localparam int MAX_LAT = (DIV_LAT > MUL_LAT) ?
                             ((DIV_LAT > ADD_LAT) ? DIV_LAT : ADD_LAT) :
                             ((MUL_LAT > ADD_LAT) ? MUL_LAT : ADD_LAT),
    localparam int DEPTH   = MAX_LAT + POST + 2,
    localparam int PW      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic [1:0]       dec_unit,
    input  logic             src_a_fp,
    input  logic [REG_W-1:0] src_a_idx,
    input  logic             src_b_fp,
    input  logic [REG_W-1:0] src_b_idx,
    input  logic             dst_fp,
    input  logic [REG_W-1:0] dst_idx,
    output logic             stall
);
    hc_unit_e          unit;
    reg_t              src_a, src_b, dst;
    logic [PW-1:0]     ins_pos, chk_pos;
    slot_t [DEPTH-1:0] slots;
    slot_t             ins_slot;
    logic              raw_hz, waw_hz, port_taken, div_busy;
    logic              dst_live, struct_hz, issue, div_start;

    assign unit  = hc_unit_e'(dec_unit);
    assign src_a = '{fp: src_a_fp, idx: src_a_idx};
    assign src_b = '{fp: src_b_fp, idx: src_b_idx};
    assign dst   = '{fp: dst_fp,   idx: dst_idx};

    always_comb begin
        unique case (unit)
            UNIT_ADD: ins_pos = PW'(ADD_LAT + POST);
            UNIT_MUL: ins_pos = PW'(MUL_LAT + POST);
            UNIT_DIV: ins_pos = PW'(DIV_LAT + POST);
            default:  ins_pos = PW'(POST);
        endcase
    end

    assign chk_pos   = ins_pos + PW'(1);
    assign dst_live  = is_live(dst);
    assign struct_hz = ((unit == UNIT_DIV) && div_busy) || (dst_live && port_taken);
    assign stall     = dec_valid && (struct_hz || raw_hz || waw_hz);
    assign issue     = dec_valid && !stall;
    assign div_start = issue && (unit == UNIT_DIV);
    assign ins_slot  = '{busy: 1'b1, long_unit: (unit != UNIT_INT), dst: dst};

    hc_scan #(.DEPTH(DEPTH), .POST(POST)) u_scan (
        .slots      (slots),
        .src_a      (src_a),
        .src_b      (src_b),
        .dst        (dst),
        .chk_pos    (chk_pos),
        .raw_hz     (raw_hz),
        .waw_hz     (waw_hz),
        .port_taken (port_taken)
    );

    hc_wb_track #(.DEPTH(DEPTH)) u_track (
        .clk      (clk),
        .rst      (rst),
        .ins_en   (issue && dst_live),
        .ins_pos  (ins_pos),
        .ins_slot (ins_slot),
        .slots_o  (slots)
    );

    hc_div_gate #(.DIV_II(DIV_II)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .busy  (div_busy)
    );

    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !stall); // R10
    AST_DIV_SPACING: assert property (@(posedge clk) disable iff (rst)
        div_start |=> !div_start); // R5
endmodule

// File: tb/hazard_gate_test.sv
module hazard_gate_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       dec_valid;
    logic [1:0] dec_unit;
    logic       src_a_fp, src_b_fp, dst_fp;
    logic [4:0] src_a_idx, src_b_idx, dst_idx;
    logic       stall;

    always #5 clk = ~clk;

    hazard_gate uut (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_unit(dec_unit),
        .src_a_fp(src_a_fp), .src_a_idx(src_a_idx),
        .src_b_fp(src_b_fp), .src_b_idx(src_b_idx),
        .dst_fp(dst_fp), .dst_idx(dst_idx), .stall(stall)
    );

    typedef struct {
        bit v; int u; bit afp; int a; bit bfp; int b; bit dfp; int d;
    } ins_t;

    int  n_chk = 0, n_fail = 0, now = 0;
    bit  done = 0;
    int  m_t[64], m_lat[64], m_dst[64];
    bit  m_ok[64], m_long[64];
    int  m_ptr = 0, last_div = -1000;

    always @(posedge clk) now <= now + 1;

    function automatic ins_t mk(bit v, int u, bit afp, int a, bit bfp, int b, bit dfp, int d);
        ins_t r;
        r.v = v; r.u = u; r.afp = afp; r.a = a; r.bfp = bfp; r.b = b; r.dfp = dfp; r.d = d;
        return r;
    endfunction

    function automatic int lat_of(int u);
        case (u)
            1: return 3;
            2: return 6;
            3: return 24;
            default: return 0;
        endcase
    endfunction

    function automatic int key(bit fp, int idx);
        return (fp ? 32 : 0) + idx;
    endfunction

    function automatic bit live_key(int k);
        return k != 0;
    endfunction

    function automatic void model_clear();
        for (int k = 0; k < 64; k++) m_ok[k] = 0;
        last_div = -1000;
    endfunction

    // Returns 0 = no stall, else the requirement number of the first hazard seen.
    function automatic int model_eval(ins_t x);
        int ka, kb, kd, wb;
        if (!x.v) return 0;
        ka = key(x.afp, x.a); kb = key(x.bfp, x.b); kd = key(x.dfp, x.d);
        if (x.u == 3 && now < last_div + 25) return 5;
        for (int k = 0; k < 64; k++) begin
            if (m_ok[k]) begin
                wb = m_t[k] + m_lat[k] + 3;
                if (wb >= now) begin
                    if (live_key(kd) && wb == now + lat_of(x.u) + 3) return 6;
                    if (now < m_t[k] + 1 + m_lat[k] &&
                        ((live_key(ka) && ka == m_dst[k]) || (live_key(kb) && kb == m_dst[k])))
                        return 3;
                    if (m_long[k] && live_key(kd) && kd == m_dst[k]) return 7;
                end
            end
        end
        return 0;
    endfunction

    function automatic void model_issue(ins_t x);
        int kd;
        kd = key(x.dfp, x.d);
        if (x.u == 3) last_div = now;
        if (live_key(kd)) begin
            m_ok[m_ptr] = 1; m_t[m_ptr] = now; m_lat[m_ptr] = lat_of(x.u);
            m_dst[m_ptr] = kd; m_long[m_ptr] = (x.u != 0);
            m_ptr = (m_ptr + 1) % 64;
        end
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, now);
        end
    endtask

    // Drives one instruction for one cycle, compares stall with the model.
    task automatic drive(ins_t x, output bit got);
        int why;
        @(negedge clk);
        dec_valid = x.v; dec_unit = 2'(x.u);
        src_a_fp = x.afp; src_a_idx = 5'(x.a);
        src_b_fp = x.bfp; src_b_idx = 5'(x.b);
        dst_fp = x.dfp; dst_idx = 5'(x.d);
        #1;
        why = model_eval(x);
        got = stall;
        if (why == 0) check(x.v ? "R2/R8/R9/R11 no-hazard" : "R10 idle", int'(stall), 0);
        else          check($sformatf("R%0d hazard", why), int'(stall), 1);
        if (x.v && why == 0) model_issue(x);
    endtask

    task automatic idle(int n);
        bit g;
        for (int i = 0; i < n; i++) drive(mk(0, 0, 0, 0, 0, 0, 0, 0), g);
    endtask

    // Holds an instruction until it issues and counts the stall cycles.
    task automatic wait_issue(ins_t x, output int stalls);
        bit g;
        stalls = 0;
        for (int i = 0; i < 100; i++) begin
            drive(x, g);
            if (!g) break;
            stalls++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; dec_valid = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        model_clear();
    endtask

    initial begin
        int s;
        bit g;
        ins_t x;
        rst = 1; dec_valid = 0; dec_unit = 0;
        src_a_fp = 0; src_a_idx = 0; src_b_fp = 0; src_b_idx = 0; dst_fp = 0; dst_idx = 0;
        void'($urandom(32'd20240611));
        model_clear();
        do_reset();

        // R1: first instruction after reset proceeds
        drive(mk(1, 3, 1, 1, 1, 2, 1, 3), g);
        check("R1 post-reset divide", int'(g), 0);

        // R2: integer producer feeds next instruction directly
        do_reset();
        drive(mk(1, 0, 0, 0, 0, 0, 0, 5), g);
        wait_issue(mk(1, 0, 0, 5, 0, 0, 0, 6), s);
        check("R2 int-to-int stalls", s, 0);

        // R3: adder dependency
        do_reset();
        drive(mk(1, 1, 1, 4, 1, 5, 1, 1), g);
        wait_issue(mk(1, 1, 1, 1, 1, 7, 1, 9), s);
        check("R3 add RAW stalls", s, 3);

        // R4: multiplier dependency
        do_reset();
        drive(mk(1, 2, 1, 4, 1, 5, 1, 2), g);
        wait_issue(mk(1, 1, 1, 2, 0, 0, 1, 9), s);
        check("R4 mul RAW stalls", s, 6);

        // R5: back-to-back divides
        do_reset();
        drive(mk(1, 3, 1, 4, 1, 5, 1, 3), g);
        wait_issue(mk(1, 3, 1, 6, 1, 7, 1, 4), s);
        check("R5 divider busy stalls", s, 24);

        // R6: adder lands on the multiplier's write-back cycle
        do_reset();
        drive(mk(1, 2, 0, 0, 0, 0, 1, 5), g);
        idle(2);
        wait_issue(mk(1, 1, 0, 0, 0, 0, 1, 6), s);
        check("R6 add/mul port collision", s, 1);
        // R6: integer op lands on the multiplier's write-back cycle
        do_reset();
        drive(mk(1, 2, 0, 0, 0, 0, 1, 5), g);
        idle(5);
        wait_issue(mk(1, 0, 0, 0, 0, 0, 0, 7), s);
        check("R6 int/mul port collision", s, 1);

        // R7: same destination behind a multiply waits through its write-back
        do_reset();
        drive(mk(1, 2, 0, 0, 0, 0, 1, 8), g);
        wait_issue(mk(1, 0, 0, 0, 0, 0, 1, 8), s);
        check("R7 WAW behind mul", s, 9);
        // R7: same destination behind an integer op does not stall
        do_reset();
        drive(mk(1, 0, 0, 0, 0, 0, 0, 9), g);
        wait_issue(mk(1, 0, 0, 0, 0, 0, 0, 9), s);
        check("R7 WAW behind int", s, 0);

        // R8: integer register 0 is never tracked
        do_reset();
        drive(mk(1, 2, 0, 0, 0, 0, 0, 0), g);
        wait_issue(mk(1, 1, 0, 0, 0, 0, 0, 0), s);
        check("R8 int r0 source/dest", s, 0);

        // R9: register spaces are separate
        do_reset();
        drive(mk(1, 2, 0, 0, 0, 0, 0, 4), g);
        wait_issue(mk(1, 1, 1, 4, 1, 0, 1, 12), s);
        check("R9 fp4 vs int4", s, 0);

        // R10: a stalled divide leaves no record; idle decode never stalls
        do_reset();
        drive(mk(1, 3, 0, 0, 0, 0, 1, 3), g);
        drive(mk(1, 3, 0, 0, 0, 0, 1, 11), g);
        check("R10 second divide stalled", int'(g), 1);
        wait_issue(mk(1, 0, 1, 11, 0, 0, 0, 0), s);
        check("R10 stalled op not recorded", s, 0);
        drive(mk(0, 3, 1, 3, 1, 3, 1, 3), g);
        check("R10 invalid never stalls", int'(g), 0);

        // R11: no write-after-read stall
        do_reset();
        drive(mk(1, 1, 1, 12, 0, 0, 1, 13), g);
        wait_issue(mk(1, 0, 0, 0, 0, 0, 1, 12), s);
        check("R11 WAR", s, 0);

        // Random traffic against the model
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 16);
            x.v   = ($urandom % 5) != 0;
            x.u   = (r < 6) ? 0 : (r < 10) ? 1 : (r < 15) ? 2 : 3;
            x.afp = $urandom % 2; x.a = int'($urandom % 4);
            x.bfp = $urandom % 2; x.b = int'($urandom % 4);
            x.dfp = $urandom % 2; x.d = int'($urandom % 4);
            drive(x, g);
            if (i == 2000) do_reset();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule